// File: doc/BRIEF.md
# Peripheral Reset Generation Unit

This block is a memory-mapped reset controller with 64 reset outputs for peripherals and processor cores. Software drives it over a simple 32-bit register bus. Writing a 1 into a control bit puts the matching line into reset. Most lines then let go by themselves after a fixed number of slow reference-clock ticks. A small set of latched lines stays in reset until software writes a 0 to that bit. Two status words report, with active-low bits, which lines are held at the moment.

The slow reference clock is modelled as a one-cycle tick-enable input in the bus clock domain. Each line is a small state machine with three states. `LN_IDLE` means the line is released. `LN_COUNT` means it is timing a self-release. `LN_HOLD` means it is latched by software. The transitions are:

- set: `LN_IDLE` to `LN_COUNT` on a 1 written to a self-releasing line.
- restart: `LN_COUNT` to `LN_COUNT`, reloading the count, on another 1 written to that line.
- expire: `LN_COUNT` to `LN_IDLE` on the last tick of the count.
- latch: `LN_IDLE` to `LN_HOLD` on a 1 written to a latched line, or on a core-reset force.
- unlatch: `LN_HOLD` to `LN_IDLE` on a 0 written to a latched line while no core force is present.

Line 0 is the core (system) reset. While it is active, every output is driven active and the latched lines are pinned in `LN_HOLD`.

Top module: `rgu_top`

## Requirements
- R1: After reset every output is inactive (0), and both status words read 0xFFFFFFFF.
- R2: A write of a 1 to bit b of the control word at 0x100 asserts line b. A write of a 1 to bit b of the control word at 0x104 asserts line 32+b. The output is 1 from the clock edge that takes the write.
- R3: A self-releasing line returns to 0 after DELAY_TICKS (default 4) tick-enable pulses sampled at the clock edges after the write edge. Writing 0 to its control bit has no effect.
- R4: Writing a 1 to a self-releasing line that is already active reloads its count to DELAY_TICKS.
- R5: Lines 12 and 56 are latched. Once asserted, they stay at 1 until a control write to their word carries a 0 in their bit (bit 12 of 0x100, bit 24 of 0x104). A write with a 1 in that bit keeps them asserted.
- R6: A read of the status word at 0x150 (lines 0..31) or 0x154 (lines 32..63) returns, in the same cycle, the inverse of those outputs: bit = 0 while the line is active, 1 when it is released.
- R7: While line 0 is active, all 64 outputs are 1. When its count ends, lines 12 and 56 stay asserted. Every other line follows its own state.
- R8: Reads of the control offsets and of any other unmapped or unaligned offset return 0. Writes to offsets other than 0x100 and 0x104 change no output.
- R9: Without tick-enable pulses, a self-releasing line never releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable marking a reference-clock tick |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while bus_rd is high, otherwise 0 |
| rst_out | output | 64 | Reset lines, 1 = held in reset |

## Verification
The assertions check the following on every cycle:
- a written 1 always makes its line active;
- a self-releasing line falls only on an edge that carried a tick;
- a latched line drops only on a write of 0 to its bit;
- line 0 being active implies every output is active;
- control-offset reads return zero.

Only the bench's scenarios can show the rest. This covers the exact release cycle after DELAY_TICKS ticks, the count reload on a repeated write, and the survival of latched lines through a core reset. It also covers the status words read back through the bus, and that writes to unmapped offsets leave every line untouched.

// File: rtl/rgu_pkg.sv
package rgu_pkg;
    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_COUNT = 2'd1,
        LN_HOLD  = 2'd2
    } line_state_e;
endpackage

// File: rtl/rgu_line.sv
module rgu_line
    import rgu_pkg::*;
#(
    parameter int DELAY_TICKS = 4,
    parameter bit IS_LATCHED  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic wr_i,
    input  logic wbit_i,
    input  logic force_hold_i,
    output logic act_o
);
    localparam int CW = $clog2(DELAY_TICKS + 1);

    line_state_e state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;

    // next-state and count logic
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            LN_IDLE: begin
                if (IS_LATCHED) begin
                    if (force_hold_i || (wr_i && wbit_i)) state_n = LN_HOLD;
                end else if (wr_i && wbit_i) begin
                    state_n = LN_COUNT;
                    cnt_n   = CW'(DELAY_TICKS);
                end
            end
            LN_COUNT: begin
                if (wr_i && wbit_i) begin
                    cnt_n = CW'(DELAY_TICKS);
                end else if (tick_i) begin
                    if (cnt_q <= CW'(1)) begin
                        state_n = LN_IDLE;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q - CW'(1);
                    end
                end
            end
            LN_HOLD: begin
                if (!force_hold_i && wr_i && !wbit_i) state_n = LN_IDLE;
            end
            default: begin
                state_n = LN_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // outputs
    always_comb begin
        act_o = (state_q != LN_IDLE);
    end

    assert_set_asserts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wbit_i) |=> act_o)
        else $error("line not asserted after write of 1");

    generate
        if (IS_LATCHED) begin : g_latch_chk
            assert_latch_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (act_o && !(wr_i && !wbit_i)) |=> act_o)
                else $error("latched line dropped without a clearing write");
        end else begin : g_timed_chk
            assert_release_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(act_o) |-> $past(tick_i))
                else $error("self-releasing line fell without a tick");
        end
    endgenerate
endmodule

// File: rtl/rgu_wdecode.sv
module rgu_wdecode #(
    parameter int                ADDR_W    = 12,
    parameter int                NUM_WORDS = 2,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 12'h100
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NUM_WORDS-1:0] wr_word
);
    generate
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
            localparam logic [ADDR_W-1:0] WADDR = CTRL_BASE + ADDR_W'(4 * w);
            assign wr_word[w] = bus_wr && (bus_addr == WADDR);
        end
    endgenerate
endmodule

// File: rtl/rgu_readmux.sv
module rgu_readmux #(
    parameter int                ADDR_W    = 12,
    parameter int                WORD_W    = 32,
    parameter int                NUM_WORDS = 2,
    parameter logic [ADDR_W-1:0] STAT_BASE = 12'h150
) (
    input  logic                        bus_rd,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [NUM_WORDS*WORD_W-1:0] line_vec,
    output logic [WORD_W-1:0]           rdata
);
    always_comb begin
        rdata = '0;
        if (bus_rd) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (bus_addr == STAT_BASE + ADDR_W'(4 * w))
                    rdata = ~line_vec[w*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/rgu_top.sv
module rgu_top #(
    parameter int                 NUM_LINES   = 64,
    parameter int                 WORD_W      = 32,
    parameter int                 ADDR_W      = 12,
    parameter logic [11:0]        CTRL_BASE   = 12'h100,
    parameter logic [11:0]        STAT_BASE   = 12'h150,
    parameter int                 DELAY_TICKS = 4,
    parameter logic [NUM_LINES-1:0] LATCH_MASK = 64'h0100_0000_0000_1000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_tick,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic [NUM_LINES-1:0] rst_out
);
    localparam int NUM_WORDS = NUM_LINES / WORD_W;
    localparam logic [ADDR_W-1:0] CTRL_LAST = ADDR_W'(CTRL_BASE) + ADDR_W'(4 * (NUM_WORDS - 1));

    logic [NUM_WORDS-1:0] wr_word;
    logic [NUM_LINES-1:0] line_act;
    logic                 core_wr;
    logic                 force_hold;

    rgu_wdecode #(
        .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .CTRL_BASE(ADDR_W'(CTRL_BASE))
    ) u_wdec (
        .bus_wr(bus_wr), .bus_addr(bus_addr), .wr_word(wr_word)
    );

    assign core_wr    = wr_word[0] && bus_wdata[0];
    assign force_hold = line_act[0] || core_wr;

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            rgu_line #(
                .DELAY_TICKS(DELAY_TICKS), .IS_LATCHED(LATCH_MASK[i])
            ) u_line (
                .clk(clk), .rst_n(rst_n), .tick_i(ref_tick),
                .wr_i(wr_word[i / WORD_W]), .wbit_i(bus_wdata[i % WORD_W]),
                .force_hold_i(force_hold), .act_o(line_act[i])
            );
        end
    endgenerate

    assign rst_out = line_act | {NUM_LINES{line_act[0]}};

    rgu_readmux #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS),
        .STAT_BASE(ADDR_W'(STAT_BASE))
    ) u_rmux (
        .bus_rd(bus_rd), .bus_addr(bus_addr), .line_vec(rst_out), .rdata(bus_rdata)
    );

    assert_core_forces_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_act[0] |-> (&rst_out))
        else $error("core reset active but some line released");

    assert_ctrl_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr >= ADDR_W'(CTRL_BASE) && bus_addr <= CTRL_LAST)
            |-> (bus_rdata == '0))
        else $error("control offset read returned nonzero");
endmodule

// File: tb/sim_rgu_top.sv
module sim_rgu_top;
    localparam int N = 64;
    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] rst_out;

    int vectors = 0;
    int fails = 0;
    string cur_req = "R1";

    int mst[N];   // 0 idle, 1 counting, 2 held
    int mcnt[N];

    always #5 clk = ~clk;

    rgu_top u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rst_out(rst_out)
    );

    function automatic bit is_latched(int i);
        return (i == 12) || (i == 56);
    endfunction

    function automatic logic [63:0] exp_vec();
        logic [63:0] v;
        for (int i = 0; i < N; i++) v[i] = (mst[i] != 0) || (mst[0] != 0);
        return v;
    endfunction

    function automatic logic [31:0] exp_read(logic [11:0] a);
        logic [63:0] v = exp_vec();
        if (a == 12'h150) return ~v[31:0];
        if (a == 12'h154) return ~v[63:32];
        return 32'h0;
    endfunction

    task automatic model_edge(bit wr, logic [11:0] a, logic [31:0] d, bit tk);
        bit force_h = (mst[0] != 0) || (wr && a == 12'h100 && d[0]);
        for (int i = 0; i < N; i++) begin
            bit w = wr && (a == (12'h100 + 12'(4 * (i / 32))));
            bit b = d[i % 32];
            if (is_latched(i)) begin
                if (mst[i] == 2) begin
                    if (!force_h && w && !b) mst[i] = 0;
                end else if (force_h || (w && b)) mst[i] = 2;
            end else if (w && b) begin
                mst[i] = 1; mcnt[i] = D;
            end else if (mst[i] == 1 && tk) begin
                if (mcnt[i] <= 1) mst[i] = 0;
                else mcnt[i] = mcnt[i] - 1;
            end
        end
    endtask

    task automatic cyc(bit wr, bit rd, logic [11:0] a, logic [31:0] d, bit tk);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; ref_tick = tk;
        #1;
        if (rd) begin
            vectors++;
            if (bus_rdata !== exp_read(a)) begin
                fails++;
                $display("FAIL %s read @%h: actual %h expected %h", cur_req, a, bus_rdata, exp_read(a));
            end
        end
        @(posedge clk);
        model_edge(wr, a, d, tk);
        #1;
        vectors++;
        if (rst_out !== exp_vec()) begin
            fails++;
            $display("FAIL %s rst_out: actual %h expected %h", cur_req, rst_out, exp_vec());
        end
    endtask

    task automatic idle(int n, bit tk);
        for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 12'h0, 32'h0, tk);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin mst[i] = 0; mcnt[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        cur_req = "R1";
        cyc(0, 1, 12'h150, 0, 0);
        cyc(0, 1, 12'h154, 0, 0);

        cur_req = "R2";
        cyc(1, 0, 12'h100, 32'h0000_0020, 0);
        cyc(1, 0, 12'h104, 32'h0000_0100, 0);
        cur_req = "R6";
        cyc(0, 1, 12'h150, 0, 0);
        cyc(0, 1, 12'h154, 0, 0);

        cur_req = "R3";
        cyc(1, 0, 12'h100, 32'h0, 1);
        idle(2, 1);
        cyc(0, 1, 12'h150, 0, 1);
        idle(2, 1);

        cur_req = "R4";
        cyc(1, 0, 12'h100, 32'h0000_0040, 1);
        idle(2, 1);
        cyc(1, 0, 12'h100, 32'h0000_0040, 1);
        idle(3, 1);
        cyc(0, 1, 12'h150, 0, 1);
        idle(2, 1);

        cur_req = "R9";
        cyc(1, 0, 12'h104, 32'h8000_0000, 0);
        idle(20, 0);
        cyc(0, 1, 12'h154, 0, 0);
        idle(5, 1);

        cur_req = "R5";
        cyc(1, 0, 12'h100, 32'h0000_1000, 0);
        idle(8, 1);
        cyc(1, 0, 12'h104, 32'h0100_0000, 1);
        cyc(1, 0, 12'h104, 32'h0100_0000, 1);
        idle(6, 1);
        cyc(0, 1, 12'h154, 0, 0);
        cyc(1, 0, 12'h100, 32'h0000_0002, 1);
        cyc(1, 0, 12'h104, 32'h0, 1);
        idle(6, 1);

        cur_req = "R7";
        cyc(1, 0, 12'h100, 32'h0000_0001, 0);
        cyc(0, 1, 12'h154, 0, 1);
        cyc(1, 0, 12'h104, 32'h0, 1);
        idle(4, 1);
        cyc(0, 1, 12'h150, 0, 0);
        cyc(0, 1, 12'h154, 0, 0);
        cyc(1, 0, 12'h100, 32'h0, 0);
        cyc(1, 0, 12'h104, 32'h0, 0);

        cur_req = "R8";
        cyc(0, 1, 12'h100, 0, 0);
        cyc(0, 1, 12'h104, 0, 0);
        cyc(0, 1, 12'h200, 0, 0);
        cyc(0, 1, 12'h152, 0, 0);
        cyc(1, 0, 12'h108, 32'hFFFF_FFFF, 0);
        cyc(1, 0, 12'h150, 32'hFFFF_FFFF, 0);
        cyc(1, 0, 12'h101, 32'hFFFF_FFFF, 0);
        cyc(0, 1, 12'h150, 0, 0);
        cyc(0, 1, 12'h154, 0, 0);

        cur_req = "R3";
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom % 16;
            int ai = $urandom % 5;
            logic [11:0] a;
            logic [31:0] d = $urandom & $urandom & $urandom;
            bit wr = (r < 3);
            bit rd = !wr && ($urandom % 2 == 0);
            if ($urandom % 40 != 0) d[0] = 1'b0;
            case (ai)
                0: a = 12'h100;
                1: a = 12'h104;
                2: a = 12'h150;
                3: a = 12'h154;
                default: a = 12'($urandom % 4096);
            endcase
            cyc(wr, rd, a, d, ($urandom % 3) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule